// File: doc/BRIEF.md
# Set-Associative TLB Command Engine

This block holds the joint translation table of a memory management unit. It keeps the entries in a set-associative array and is driven entirely through four software-visible registers: a tag word, a data word, an index word and a command word. Software loads the tag and data words and the index, then writes a command code. The engine can look up the tag, choose a slot for a new tag, read an entry back, or commit the tag and data words to the slot named by the index. A commit can optionally tell the downstream micro-TLBs to drop their copies, and an explicit micro-TLB invalidate is also available.

Every register access takes one clock and has no back-pressure. A command runs at the clock edge where the command word is written, using the register contents from before that edge. Its results can be read from the next cycle on. The interface has no data stream, so it carries no valid/ready handshake. The micro-TLB invalidate output is a plain one-cycle pulse and does not wait for any acknowledge.

The tag word is laid out as follows. Bits 31 down to the page shift (13 by default) hold the virtual page number, and the low set bits of that number select the set. Bit 10 is the present flag, bit 8 is the global flag and bits 7:0 hold the ASID.

Top module: `tlbe_engine`

## Requirements
- R1: After reset the tag, data and index registers read 0 and every entry is invalid, so a lookup misses.
- R2: A register write with reg_addr 0 (tag), 1 (data) or 2 (index) is readable on the next cycle at the same address. Address 3 is the command register and reads 0.
- R3: Command code 2 stores the tag and data words at the slot named by index bits [IDX_W-1:0]. Command code 1 loads both words from that slot. The slot number equals set × WAYS + way.
- R4: Command code 2 drives utlb_inv high for exactly the one cycle after the command edge. Command code 3 stores the entry in the same way but leaves utlb_inv low.
- R5: Command code 6 pulses utlb_inv for one cycle and changes no stored entry.
- R6: Command code 4 (probe) with exactly one matching way writes that slot number into the index register, with bits 31 and 30 clear.
- R7: A probe that matches no way sets the index register to 0x8000_0000: bit 31 set, bit 30 clear, slot field zero.
- R8: A probe that matches more than one way sets the index register to 0xC000_0000: bits 31 and 30 both set.
- R9: An entry matches only when its present bit (tag bit 10) is set and its page number equals the probe's. The ASID (bits 7:0) must also be equal, unless the entry's global bit (bit 8) is set.
- R10: Command code 5 writes into the index register the slot of the lowest-numbered invalid way in the tag's set, with bits 31 and 30 clear.
- R11: When every way of the set is valid, command code 5 takes the way from a per-set round-robin pointer. The pointer starts at way 0 after reset and advances by one, wrapping, on each such use.
- R12: Storing an all-zero tag word erases the entry, so later probes miss it and it counts as free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 tag, 1 data, 2 index, 3 command |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the register at reg_addr (combinational) |
| utlb_inv | output | 1 | One-cycle micro-TLB invalidate pulse |

## Verification
Probes are tried in several forms, and each result is checked against an expected value. An exact hit in one way of a set is checked against a hit in the other way of the same set, which shows that the way is encoded into the slot number. The same page under another ASID tells the ASID compare apart from the global bypass. A set holding no entries and a tag without its present bit must both give a miss, and two identical entries must give the duplicate code. Victim choice is tried on a set with one free way, on a full set repeated three times to show the wrap, and on a set with a freshly erased way. The invalidate pulse is compared across the plain commit, the commit without invalidate and the explicit invalidate.

// File: rtl/tlbe_pkg.sv
package tlbe_pkg;
  localparam int PD_W = 32;

  // command codes written to the command register
  typedef enum logic [2:0] {
    CMD_NONE     = 3'd0,
    CMD_READ     = 3'd1,
    CMD_WRITE    = 3'd2,
    CMD_WRITE_NI = 3'd3,
    CMD_PROBE    = 3'd4,
    CMD_GETIDX   = 3'd5,
    CMD_UINV     = 3'd6
  } cmd_e;

  localparam logic [1:0] RA_TAG = 2'd0;
  localparam logic [1:0] RA_DAT = 2'd1;
  localparam logic [1:0] RA_IDX = 2'd2;
  localparam logic [1:0] RA_CMD = 2'd3;

  localparam int BIT_PRESENT = 10;
  localparam int BIT_GLOBAL  = 8;
  localparam int ASID_W      = 8;
  localparam int BIT_MISS    = 31;
  localparam int BIT_DUP     = 30;

  typedef struct packed {
    logic [PD_W-1:0] tag;
    logic [PD_W-1:0] dat;
  } entry_t;
endpackage

// File: rtl/tlbe_store.sv
module tlbe_store
  import tlbe_pkg::*;
#(
  parameter int SETS = 128,
  parameter int WAYS = 2,
  localparam int SET_W = $clog2(SETS),
  localparam int DEPTH = SETS * WAYS,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [SET_W-1:0]           set_sel,
  output logic [WAYS-1:0][PD_W-1:0]  set_tags,
  input  logic [IDX_W-1:0]           rd_idx,
  output entry_t                     rd_ent,
  input  logic                       we,
  input  logic [IDX_W-1:0]           wr_idx,
  input  entry_t                     wr_ent
);
  entry_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[wr_idx] <= wr_ent;
    end
  end

  logic [IDX_W-1:0] base;
  assign base = IDX_W'(set_sel) * IDX_W'(WAYS);

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign set_tags[w] = mem[base + IDX_W'(w)].tag;
  end

  assign rd_ent = mem[rd_idx];

  AST_STORE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (mem[$past(wr_idx)] == $past(wr_ent))); // R3
endmodule

// File: rtl/tlbe_match.sv
module tlbe_match
  import tlbe_pkg::*;
#(
  parameter int WAYS = 2,
  parameter int PAGE_SHIFT = 13
) (
  input  logic [WAYS-1:0][PD_W-1:0] set_tags,
  input  logic [PD_W-1:0]           key,
  output logic [WAYS-1:0]           hit
);
  localparam logic [PD_W-1:0] VPN_MASK  = {{(PD_W-PAGE_SHIFT){1'b1}}, {PAGE_SHIFT{1'b0}}};
  localparam logic [PD_W-1:0] ASID_MASK = PD_W'((1 << ASID_W) - 1);

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    logic [PD_W-1:0] care;
    always_comb begin
      care = VPN_MASK | (set_tags[w][BIT_GLOBAL] ? '0 : ASID_MASK);
      hit[w] = set_tags[w][BIT_PRESENT] && (((set_tags[w] ^ key) & care) == '0);
    end
  end
endmodule

// File: rtl/tlbe_victim.sv
module tlbe_victim #(
  parameter int SETS = 128,
  parameter int WAYS = 2,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SET_W-1:0] set_sel,
  input  logic [WAYS-1:0]  valid,
  input  logic             take,
  output logic [WAY_W-1:0] way_out
);
  logic [WAY_W-1:0] rr_q [SETS];
  logic             free_found;

  always_comb begin
    free_found = 1'b0;
    way_out    = rr_q[set_sel];
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!valid[w]) begin
        way_out    = WAY_W'(w);
        free_found = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) rr_q[s] <= '0;
    end else if (take && !free_found) begin
      rr_q[set_sel] <= (rr_q[set_sel] == WAY_W'(WAYS - 1)) ? '0 : rr_q[set_sel] + 1'b1;
    end
  end

  AST_VICTIM_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !(&valid)) |-> !valid[way_out]); // R10
  AST_RR_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
    (take && (&valid)) |=> (rr_q[$past(set_sel)] != $past(way_out))); // R11
endmodule

// File: rtl/tlbe_engine.sv
module tlbe_engine
  import tlbe_pkg::*;
#(
  parameter int SETS = 128,
  parameter int WAYS = 2,
  parameter int PAGE_SHIFT = 13
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        utlb_inv
);
  localparam int SET_W = $clog2(SETS);
  localparam int DEPTH = SETS * WAYS;
  localparam int IDX_W = $clog2(DEPTH);
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;
  localparam int CNT_W = WAY_W + 1;

  logic [PD_W-1:0] tag_q, dat_q, idx_q;
  logic            inv_q;

  logic cmd_go;
  cmd_e cmd;
  assign cmd_go = reg_we && (reg_addr == RA_CMD);
  assign cmd    = cmd_e'(reg_wdata[2:0]);

  logic [SET_W-1:0] set_sel;
  logic [IDX_W-1:0] cur_idx;
  assign set_sel = tag_q[PAGE_SHIFT +: SET_W];
  assign cur_idx = idx_q[IDX_W-1:0];

  logic [WAYS-1:0][PD_W-1:0] set_tags;
  entry_t                    rd_ent;
  logic                      st_we;
  logic [WAYS-1:0]           hit, valid;
  logic [WAY_W-1:0]          vic_way, hit_way;
  logic [CNT_W-1:0]          nhit;
  logic [IDX_W-1:0]          hit_lin, vic_lin;

  assign st_we = cmd_go && (cmd == CMD_WRITE || cmd == CMD_WRITE_NI);

  tlbe_store #(.SETS(SETS), .WAYS(WAYS)) u_store (
    .clk(clk), .rst_n(rst_n), .set_sel(set_sel), .set_tags(set_tags),
    .rd_idx(cur_idx), .rd_ent(rd_ent), .we(st_we), .wr_idx(cur_idx),
    .wr_ent('{tag: tag_q, dat: dat_q})
  );

  tlbe_match #(.WAYS(WAYS), .PAGE_SHIFT(PAGE_SHIFT)) u_match (
    .set_tags(set_tags), .key(tag_q), .hit(hit)
  );

  for (genvar w = 0; w < WAYS; w++) begin : g_valid
    assign valid[w] = set_tags[w][BIT_PRESENT];
  end

  tlbe_victim #(.SETS(SETS), .WAYS(WAYS)) u_victim (
    .clk(clk), .rst_n(rst_n), .set_sel(set_sel), .valid(valid),
    .take(cmd_go && cmd == CMD_GETIDX), .way_out(vic_way)
  );

  // count matches and encode the lowest matching way
  always_comb begin
    nhit    = '0;
    hit_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (hit[w]) hit_way = WAY_W'(w);
      nhit = nhit + CNT_W'(hit[w]);
    end
  end

  assign hit_lin = IDX_W'(set_sel) * IDX_W'(WAYS) + IDX_W'(hit_way);
  assign vic_lin = IDX_W'(set_sel) * IDX_W'(WAYS) + IDX_W'(vic_way);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tag_q <= '0;
      dat_q <= '0;
      idx_q <= '0;
      inv_q <= 1'b0;
    end else begin
      inv_q <= cmd_go && (cmd == CMD_WRITE || cmd == CMD_UINV);
      if (reg_we) begin
        case (reg_addr)
          RA_TAG:  tag_q <= reg_wdata;
          RA_DAT:  dat_q <= reg_wdata;
          RA_IDX:  idx_q <= reg_wdata;
          default: ;
        endcase
      end
      if (cmd_go) begin
        case (cmd)
          CMD_READ: begin
            tag_q <= rd_ent.tag;
            dat_q <= rd_ent.dat;
          end
          CMD_PROBE: begin
            if (nhit == '0) begin
              idx_q <= '0;
              idx_q[BIT_MISS] <= 1'b1;
            end else if (nhit == CNT_W'(1)) begin
              idx_q <= PD_W'(hit_lin);
            end else begin
              idx_q <= '0;
              idx_q[BIT_MISS] <= 1'b1;
              idx_q[BIT_DUP]  <= 1'b1;
            end
          end
          CMD_GETIDX: idx_q <= PD_W'(vic_lin);
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (reg_addr)
      RA_TAG:  reg_rdata = tag_q;
      RA_DAT:  reg_rdata = dat_q;
      RA_IDX:  reg_rdata = idx_q;
      default: reg_rdata = '0;
    endcase
  end

  assign utlb_inv = inv_q;

  AST_INV_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    utlb_inv |-> $past(cmd_go && (cmd == CMD_WRITE || cmd == CMD_UINV))); // R4
  AST_NI_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_go && cmd == CMD_WRITE_NI) |=> !utlb_inv); // R4
  AST_MISS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_go && cmd == CMD_PROBE && hit == '0) |=> (idx_q[BIT_MISS] && !idx_q[BIT_DUP])); // R7
  AST_DUP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_go && cmd == CMD_PROBE && $countones(hit) > 1) |=> (idx_q[BIT_MISS] && idx_q[BIT_DUP])); // R8
  AST_HIT_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_go && cmd == CMD_PROBE && $onehot(hit)) |=> !idx_q[BIT_MISS]); // R6
  AST_GETIDX_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_go && cmd == CMD_GETIDX) |=> (idx_q[BIT_MISS:BIT_DUP] == 2'b00)); // R10
endmodule

// File: tb/sim_tlbe_engine.sv
`timescale 1ns/1ps
module sim_tlbe_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        utlb_inv;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  tlbe_engine u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .utlb_inv(utlb_inv)
  );

  localparam logic [1:0] A_TAG = 2'd0, A_DAT = 2'd1, A_IDX = 2'd2, A_CMD = 2'd3;
  localparam logic [31:0] C_READ = 1, C_WRITE = 2, C_WNI = 3, C_PROBE = 4, C_GETIDX = 5, C_UINV = 6;
  localparam logic [31:0] MISS = 32'h8000_0000, DUP = 32'hC000_0000;

  typedef struct packed { logic [31:0] tag; logic [31:0] dat; logic [31:0] idx; } load_t;
  typedef struct packed { logic [31:0] key; logic [31:0] expect_idx; } probe_t;

  // entries: set 1 way 0, set 1 way 1, set 2 way 1 (global)
  localparam load_t LOADS [3] = '{
    '{tag: 32'h0000_2405, dat: 32'h1111_0001, idx: 32'd2},
    '{tag: 32'h0010_2405, dat: 32'h2222_0002, idx: 32'd3},
    '{tag: 32'h0000_4500, dat: 32'h3333_0003, idx: 32'd5}
  };

  localparam probe_t PROBES [5] = '{
    '{key: 32'h0000_2405, expect_idx: 32'd2},   // R6 way 0
    '{key: 32'h0010_2405, expect_idx: 32'd3},   // R6 way 1
    '{key: 32'h0010_2407, expect_idx: MISS},    // R9 ASID differs
    '{key: 32'h0000_4409, expect_idx: 32'd5},   // R9 global bypass
    '{key: 32'h0000_6405, expect_idx: MISS}     // R7 empty set
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a;
    #0.5;
    d = reg_rdata;
  endtask

  task automatic store(input logic [31:0] t, input logic [31:0] dt, input logic [31:0] i,
                       input logic [31:0] c);
    wr(A_TAG, t); wr(A_DAT, dt); wr(A_IDX, i); wr(A_CMD, c);
  endtask

  task automatic probe(input logic [31:0] key, output logic [31:0] res);
    wr(A_TAG, key); wr(A_CMD, C_PROBE); rd(A_IDX, res);
  endtask

  task automatic getidx(input logic [31:0] key, output logic [31:0] res);
    wr(A_TAG, key); wr(A_CMD, C_GETIDX); rd(A_IDX, res);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(A_TAG, v); check("R1 tag reset", v, 0);
    rd(A_DAT, v); check("R1 data reset", v, 0);
    rd(A_IDX, v); check("R1 index reset", v, 0);
    probe(32'h0000_2405, v); check("R1 empty probe", v, MISS);

    // R2 register readback
    wr(A_IDX, 32'h0000_005A); rd(A_IDX, v); check("R2 index readback", v, 32'h5A);
    wr(A_DAT, 32'hA5A5_0F0F); rd(A_DAT, v); check("R2 data readback", v, 32'hA5A5_0F0F);
    rd(A_CMD, v); check("R2 command reads zero", v, 0);

    // table of loads; R4 pulse after each plain commit
    for (int i = 0; i < 3; i++) begin
      store(LOADS[i].tag, LOADS[i].dat, LOADS[i].idx, C_WRITE);
      check("R4 write pulses", 32'(utlb_inv), 1);
      @(negedge clk);
      check("R4 pulse lasts one cycle", 32'(utlb_inv), 0);
    end

    // table of probes
    for (int i = 0; i < 5; i++) begin
      probe(PROBES[i].key, v);
      check("R6/R7/R9 probe table", v, PROBES[i].expect_idx);
    end

    // R3 read back slot 3
    wr(A_TAG, 0); wr(A_DAT, 0); wr(A_IDX, 3); wr(A_CMD, C_READ);
    rd(A_TAG, v); check("R3 read tag", v, 32'h0010_2405);
    rd(A_DAT, v); check("R3 read data", v, 32'h2222_0002);

    // R4 write without invalidate
    store(32'h0000_C405, 32'h4444_0004, 32'd12, C_WNI);
    check("R4 write-ni no pulse", 32'(utlb_inv), 0);
    probe(32'h0000_C405, v); check("R3 write-ni stored at 12", v, 12);

    // R5 explicit invalidate
    wr(A_CMD, C_UINV);
    check("R5 invalidate pulses", 32'(utlb_inv), 1);
    probe(32'h0010_2405, v); check("R5 entries unchanged", v, 3);

    // R11 full set round robin
    getidx(32'h0000_2405, v); check("R11 rr first", v, 2);
    getidx(32'h0000_2405, v); check("R11 rr second", v, 3);
    getidx(32'h0000_2405, v); check("R11 rr wrap", v, 2);

    // R10 free way preferred (set 2: way 0 empty)
    getidx(32'h0000_4500, v); check("R10 free way", v, 4);

    // R8 duplicate
    store(32'h0000_4500, 32'h5555_0005, 32'd4, C_WRITE);
    probe(32'h0000_4405, v); check("R8 duplicate code", v, DUP);

    // R12 erase
    store(32'h0, 32'h0, 32'd2, C_WRITE);
    probe(32'h0000_2405, v); check("R12 erased entry misses", v, MISS);
    getidx(32'h0000_2405, v); check("R12 erased way free", v, 2);

    // R9 entry without present bit
    store(32'h0000_8005, 32'h6666_0006, 32'd8, C_WRITE);
    probe(32'h0000_8005, v); check("R9 not present misses", v, MISS);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule